// File: doc/BRIEF.md
# Interrupt entry and return controller

This block sits beside a small pipelined processor core and decides when the core must leave its instruction stream to run an interrupt handler. Each interrupt source owns a sticky flag that is set by its event whatever the enables hold. A source counts as pending only if its own enable bit is set. Sources that belong to the peripheral group also need the group enable. A qualified source is taken only while the global enable is set. Some sources come from the core's clock domain. Others are asynchronous and first pass through a two-flop synchronizer and a rising-edge detector.

Taking an interrupt produces a one-cycle redirect. The block flushes the prefetched instruction, loads the program counter with the fixed vector 0x0004 and clears the global enable. It also saves the core's current program counter on an internal eight-entry return stack with a wrapping pointer. A return strobe from the core pops the saved address, loads it into the program counter and sets the global enable again in the same step. Software reaches the flags, the enables and the pending set through a small register select and read/write port.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the global enable, the peripheral-group enable, all source enables and all flags read 0, and flush, pc_load and busy are low.
- R2: An interrupt is taken only while the global enable is set and the source's enable bit is set. A source inside PERIPH_MASK also needs the peripheral-group enable. With the group enable clear, such a source causes no redirect.
- R3: A source's event sets its flag on the next clock edge whatever any enable holds. The flags are read and written at select 2 (bit i is source i).
- R4: In the cycle after a qualified interrupt is seen, flush, pc_load and busy are high for exactly one cycle and pc_target is 0x0004. From that edge the global enable (bit 0 at select 0) reads 0.
- R5: The core's pc at the taking edge is pushed. A return strobe accepted while busy is low gives, on the next cycle, pc_load high with flush low and pc_target equal to the popped address, and the global enable reads 1.
- R6: A flag stays set until software writes it to 0. A flag left set when the handler returns causes the same interrupt to be taken again.
- R7: An event that arrives while the global enable is clear only sets its flag. It is taken once the global enable is set by a write to select 0 (bit 0 global, bit 1 peripheral group).
- R8: An asynchronous input sets its flag on the third rising clock edge after it rises (not on the second), and a level held high sets the flag only once.
- R9: A flag write that clears a flag in the same cycle as a new event on that source leaves the flag set.
- R10: busy is high for one cycle per entry. A return strobe while busy is high is ignored.
- R11: The return stack is eight entries deep and last-in-first-out, so nested handlers return in reverse order of entry.
- R12: Select 3 reads the pending set, flags AND enables AND the group gate, and select 1 reads and writes the source enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_sync | input | N_SRC-N_ASYNC | Core-domain event pulses, sources 0 upward |
| evt_async | input | N_ASYNC | Asynchronous event levels, highest-numbered sources |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 enables, 2 flags, 3 pending (read only) |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data for reg_sel |
| core_pc | input | PC_W | Program counter of the core, saved on entry |
| ret_req | input | 1 | Return-from-interrupt strobe |
| flush | output | 1 | Discard the prefetched instruction |
| pc_load | output | 1 | Load pc_target into the program counter |
| pc_target | output | PC_W | Vector or return address |
| busy | output | 1 | Redirect sequence in progress |

## Verification
The bench builds the block with four sources: two ungated core-domain sources, one gated core-domain source and one gated asynchronous source. With these values, ungated and group-gated qualification and synchronizer latency can all be tested within a few hundred cycles. The eight-entry stack is kept, and three nested handlers test last-in-first-out order. A behavioural model compares flush, pc_load, busy, pc_target and the read port on every clock.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_PEND = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_REDIR = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic take;
        logic ret;
    } seq_cmd_t;

    localparam int unsigned IRQ_VECTOR = 4;

endpackage

// File: rtl/irq_async_edge.sv
module irq_async_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_sync
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= raw[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign pulse[i] = s2_q & ~s3_q;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_entry_pkg::*;
#(
    parameter int               N_SRC       = 8,
    parameter logic [N_SRC-1:0] PERIPH_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt,
    input  logic             reg_we,
    input  reg_sel_e         reg_sel,
    input  logic [N_SRC-1:0] wdata,
    input  seq_cmd_t         cmd,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] en,
    output logic [N_SRC-1:0] pend,
    output logic             ge,
    output logic             pe
);
    logic [N_SRC-1:0] flags_q, en_q, gate;
    logic             ge_q, pe_q;
    logic             wr_ctl, wr_en, wr_flag;

    assign wr_ctl  = reg_we && (reg_sel == SEL_CTL);
    assign wr_en   = reg_we && (reg_sel == SEL_EN);
    assign wr_flag = reg_we && (reg_sel == SEL_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            en_q    <= '0;
            ge_q    <= 1'b0;
            pe_q    <= 1'b0;
        end else begin
            flags_q <= (wr_flag ? wdata : flags_q) | evt;
            if (wr_en)  en_q <= wdata;
            if (wr_ctl) pe_q <= wdata[1];
            if (cmd.take)     ge_q <= 1'b0;
            else if (cmd.ret) ge_q <= 1'b1;
            else if (wr_ctl)  ge_q <= wdata[0];
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
        if (PERIPH_MASK[i]) begin : g_periph
            assign gate[i] = pe_q;
        end else begin : g_plain
            assign gate[i] = 1'b1;
        end
    end

    assign pend  = flags_q & en_q & gate;
    assign flags = flags_q;
    assign en    = en_q;
    assign ge    = ge_q;
    assign pe    = pe_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!ge_q && !pe_q && en_q == '0 && flags_q == '0));

    // R3
    flag_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PC_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (push) begin
            mem[ptr_q] <= push_data;
            ptr_q      <= ptr_q + PTR_W'(1);
        end else if (pop) begin
            ptr_q <= ptr_q - PTR_W'(1);
        end
    end

    assign top = mem[ptr_q - PTR_W'(1)];

    // R11
    push_advance_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> (ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1))));

    // R11
    pop_return_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (top == $past(push_data)));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int               N_SRC       = 8,
    parameter int               N_ASYNC     = 2,
    parameter logic [N_SRC-1:0] PERIPH_MASK = 8'hF0,
    parameter int               PC_W        = 13,
    parameter int               STK_DEPTH   = 8,
    localparam int              N_SYNC      = N_SRC - N_ASYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SYNC-1:0] evt_sync,
    input  logic [N_ASYNC-1:0] evt_async,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [N_SRC-1:0]  reg_wdata,
    output logic [N_SRC-1:0]  reg_rdata,
    input  logic [PC_W-1:0]   core_pc,
    input  logic              ret_req,
    output logic              flush,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_target,
    output logic              busy
);
    localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VECTOR);

    logic [N_ASYNC-1:0] async_pulse;
    logic [N_SRC-1:0]   evt, flags, en, pend;
    logic               ge, pe;
    seq_cmd_t           cmd;
    seq_state_e         state_q;
    logic               flush_q, load_q;
    logic [PC_W-1:0]    tgt_q, stack_top;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(reg_sel);
    assign evt = {async_pulse, evt_sync};

    irq_async_edge #(.N(N_ASYNC)) u_async (
        .clk   (clk),
        .rst   (rst),
        .raw   (evt_async),
        .pulse (async_pulse)
    );

    irq_flag_bank #(.N_SRC(N_SRC), .PERIPH_MASK(PERIPH_MASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .reg_we  (reg_we),
        .reg_sel (sel),
        .wdata   (reg_wdata),
        .cmd     (cmd),
        .flags   (flags),
        .en      (en),
        .pend    (pend),
        .ge      (ge),
        .pe      (pe)
    );

    irq_ret_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd.take),
        .pop       (cmd.ret),
        .push_data (core_pc),
        .top       (stack_top)
    );

    // return wins over entry in the same cycle; nothing is accepted while busy
    always_comb begin
        cmd.ret  = ret_req && (state_q == SEQ_IDLE);
        cmd.take = ge && (|pend) && (state_q == SEQ_IDLE) && !ret_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            flush_q <= 1'b0;
            load_q  <= 1'b0;
            tgt_q   <= '0;
        end else begin
            state_q <= cmd.take ? SEQ_REDIR : SEQ_IDLE;
            flush_q <= cmd.take;
            load_q  <= cmd.take | cmd.ret;
            if (cmd.take)     tgt_q <= VEC;
            else if (cmd.ret) tgt_q <= stack_top;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTL:  reg_rdata = {{(N_SRC-2){1'b0}}, pe, ge};
            SEL_EN:   reg_rdata = en;
            SEL_FLAG: reg_rdata = flags;
            default:  reg_rdata = pend;
        endcase
    end

    assign flush     = flush_q;
    assign pc_load   = load_q;
    assign pc_target = tgt_q;
    assign busy      = (state_q == SEQ_REDIR);

    // R4
    redirect_vector_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (pc_load && busy && pc_target == VEC && !ge));

    // R2
    entry_needs_ge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flush) |-> $past(ge));

    // R10
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R5
    return_restores_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !busy) |=> (pc_load && !flush && ge));
endmodule

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int NS    = 4;
    localparam int PCW   = 13;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     evt_sync = '0;
    logic [0:0]     evt_async = '0;
    logic           reg_we = 1'b0;
    logic [1:0]     reg_sel = '0;
    logic [NS-1:0]  reg_wdata = '0;
    logic [NS-1:0]  reg_rdata;
    logic [PCW-1:0] core_pc = '0;
    logic           ret_req = 1'b0;
    logic           flush, pc_load, busy;
    logic [PCW-1:0] pc_target;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_entry_ctrl #(
        .N_SRC(NS), .N_ASYNC(1), .PERIPH_MASK(4'b1100),
        .PC_W(PCW), .STK_DEPTH(8)
    ) u_dut (
        .clk(clk), .rst(rst), .evt_sync(evt_sync), .evt_async(evt_async),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_pc(core_pc), .ret_req(ret_req),
        .flush(flush), .pc_load(pc_load), .pc_target(pc_target), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [3:0] m_flags, m_en;
    bit         m_ge, m_pe, m_busy, m_flush, m_load;
    int         m_tgt;
    bit         a1, a2, a3;
    int         m_stk [8];
    int         m_ptr;

    always @(posedge clk) begin
        if (rst) begin
            m_flags = 0; m_en = 0; m_ge = 0; m_pe = 0;
            m_busy = 0; m_flush = 0; m_load = 0; m_tgt = 0;
            a1 = 0; a2 = 0; a3 = 0; m_ptr = 0;
        end else begin
            logic [3:0] ev, pend, nf;
            bit take, rok;
            ev = {a2 & ~a3, evt_sync};
            pend = m_flags & m_en & {m_pe, m_pe, 2'b11};
            rok  = ret_req && !m_busy;
            take = m_ge && (pend != 0) && !m_busy && !ret_req;
            nf = (reg_we && reg_sel == 2) ? reg_wdata : m_flags;
            m_flags = nf | ev;
            if (reg_we && reg_sel == 1) m_en = reg_wdata;
            if (reg_we && reg_sel == 0) m_pe = reg_wdata[1];
            if (take) m_ge = 0;
            else if (rok) m_ge = 1;
            else if (reg_we && reg_sel == 0) m_ge = reg_wdata[0];
            m_flush = take; m_busy = take; m_load = take || rok;
            if (take) begin
                m_tgt = 4;
                m_stk[m_ptr] = int'(core_pc);
                m_ptr = (m_ptr + 1) % 8;
            end else if (rok) begin
                m_ptr = (m_ptr + 7) % 8;
                m_tgt = m_stk[m_ptr];
            end
            a3 = a2; a2 = a1; a1 = evt_async[0];
        end
    end

    function automatic int model_rd(input logic [1:0] s);
        case (s)
            2'd0: return {m_pe, m_ge};
            2'd1: return m_en;
            2'd2: return m_flags;
            default: return m_flags & m_en & {m_pe, m_pe, 2'b11};
        endcase
    endfunction

    int n_entry = 0;
    int n_ret = 0;
    int ret_log [$];

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 flush vs model", flush, m_flush);
            chk("R10 busy vs model", busy, m_busy);
            chk("R5 pc_load vs model", pc_load, m_load);
            if (m_load) chk("R5 pc_target vs model", pc_target, m_tgt);
            chk("R12 read port vs model", reg_rdata, model_rd(reg_sel));
            if (flush) begin
                n_entry++;
                chk("R4 vector", pc_target, 4);
            end
            if (pc_load && !flush) begin
                n_ret++;
                ret_log.push_back(int'(pc_target));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] d);
        reg_we = 1; reg_sel = s; reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_sync(input logic [2:0] m);
        evt_sync = m;
        step();
        evt_sync = 0;
    endtask

    task automatic do_ret();
        ret_req = 1;
        step();
        ret_req = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int e0;
        idle(3);
        rst = 0;
        step();
        chk("R1 flush after reset", flush, 0);
        chk("R1 busy after reset", busy, 0);
        rd(0, v); chk("R1 control after reset", v, 0);
        rd(1, v); chk("R1 enables after reset", v, 0);
        rd(2, v); chk("R1 flags after reset", v, 0);

        // R3: flag recorded with everything disabled
        pulse_sync(3'b001);
        rd(2, v); chk("R3 flag set with enables clear", v, 1);
        idle(2);
        chk("R2 no entry while disabled", n_entry, 0);

        // R7: enabled source, global enable still clear
        wr(1, 4'b0001);
        idle(3);
        chk("R7 no entry while global clear", n_entry, 0);
        rd(3, v); chk("R12 pending set", v, 1);
        rd(1, v); chk("R12 enable readback", v, 1);

        // R4/R7: set global enable, entry follows
        core_pc = 13'h123;
        wr(0, 4'b0001);
        idle(3);
        chk("R7 serviced after global set", n_entry, 1);
        rd(0, v); chk("R4 global cleared on entry", v & 1, 0);

        // R6: return with flag still set -> taken again
        do_ret();
        idle(3);
        chk("R5 return count", n_ret, 1);
        chk("R5 return address", ret_log[$], 'h123);
        chk("R6 retaken with flag left set", n_entry, 2);

        wr(2, 4'b0000);
        do_ret();
        idle(3);
        chk("R6 no retake once cleared", n_entry, 2);
        rd(0, v); chk("R5 global set by return", v & 1, 1);

        // R2: peripheral source needs group enable
        wr(1, 4'b0100);
        pulse_sync(3'b100);
        idle(3);
        chk("R2 peripheral blocked by group enable", n_entry, 2);
        wr(0, 4'b0011);
        idle(3);
        chk("R2 peripheral taken with group enable", n_entry, 3);
        wr(2, 4'b0000);
        do_ret();
        idle(2);

        // R9: clear write races a new event
        reg_we = 1; reg_sel = 2; reg_wdata = 4'b0000; evt_sync = 3'b010;
        step();
        reg_we = 0; evt_sync = 0;
        rd(2, v); chk("R9 flag kept on clear/event collision", v, 4'b0010);
        wr(2, 4'b0000);

        // R8: asynchronous source latency and single edge
        wr(1, 4'b1000);
        e0 = n_entry;
        evt_async = 1;
        idle(2);
        rd(2, v); chk("R8 async flag not yet set", v, 0);
        step();
        rd(2, v); chk("R8 async flag set on third edge", v, 4'b1000);
        idle(3);
        chk("R8 async entry", n_entry, e0 + 1);
        wr(2, 4'b0000);
        do_ret();
        idle(5);
        chk("R8 held level sets flag once", n_entry, e0 + 1);
        rd(2, v); chk("R8 no second flag", v, 0);
        evt_async = 0;
        idle(3);

        // R10: return strobe while busy is ignored
        wr(1, 4'b0001);
        e0 = n_ret;
        pulse_sync(3'b001);
        step();
        chk("R10 busy high after entry", busy, 1);
        do_ret();
        idle(2);
        chk("R10 return ignored while busy", n_ret, e0);
        wr(2, 4'b0000);
        do_ret();
        idle(2);

        // R11: three nested handlers return in reverse order
        wr(1, 4'b0011);
        core_pc = 13'h100;
        pulse_sync(3'b001);
        idle(3);
        wr(2, 4'b0000);
        core_pc = 13'h200;
        wr(0, 4'b0011);
        pulse_sync(3'b010);
        idle(3);
        wr(2, 4'b0000);
        core_pc = 13'h300;
        wr(0, 4'b0011);
        pulse_sync(3'b001);
        idle(3);
        wr(2, 4'b0000);
        e0 = n_ret;
        do_ret(); idle(2);
        do_ret(); idle(2);
        do_ret(); idle(2);
        chk("R11 nested return count", n_ret, e0 + 3);
        chk("R11 first return", ret_log[e0], 'h300);
        chk("R11 second return", ret_log[e0 + 1], 'h200);
        chk("R11 third return", ret_log[e0 + 2], 'h100);

        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule